// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter that sits beside a monitored pipeline. Every cycle the pipeline presents a small per-cycle count for each of a set of sub-events, arranged in groups of eight. Software picks a group with an 8-bit event code and picks any subset of that group's eight sub-events with an 8-bit unit mask. The counts of the chosen sub-events are added together, so a wide mask counts the union of the selected sub-events.

Before the counter moves, the selected per-cycle count passes through a set of qualifiers. A nonzero threshold turns the counter into a cycle counter that adds one in each cycle whose count reaches the threshold. An inversion flag reverses that compare, which counts stall cycles. An edge flag counts only the cycles where the qualified condition turns on. A privilege filter restricts counting to the supervisor level, to the user levels, or to both. The counter can be preset through a small register port. On a wrap it sets a sticky overflow flag, which can raise an interrupt.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the configuration word, the counter and the overflow flag read as zero, and `irq` is low.
- R2: The selected count is the sum of the per-cycle counts of sub-events `s` (mask bit `s` set) in group `g` equal to the event code. Sub-event `s` of group `g` occupies bits `[(g*8+s)*SUB_W +: SUB_W]` of `ev_counts`. A code of `NUM_GROUPS` or more selects nothing.
- R3: With a threshold of zero, each qualifying cycle adds the selected count, saturated at `2**INC_W-1` (15 by default).
- R4: With a nonzero threshold, each qualifying cycle whose selected count is greater than or equal to the threshold adds exactly one.
- R5: With a nonzero threshold and inversion set, one is added in cycles whose count is below the threshold. With a zero threshold, inversion has no effect.
- R6: With edge set, one is added only in a cycle where the qualified condition is true and was false in the previous cycle.
- R7: The supervisor flag allows counting at privilege level 0, and the user flag allows levels 1 to 3. With both flags clear, every level counts.
- R8: With the enable bit clear, the counter does not change.
- R9: Writing the counter address presets the counter. A write to the counter or to the configuration takes the place of any increment in that cycle.
- R10: A carry out of the counter's top bit sets the sticky overflow flag. Writing a 1 to bit 0 of the status address clears it, and a wrap in the same cycle takes priority over the clear. `irq` is high while the flag is set and the interrupt-enable bit is 1.
- R11: A configuration write clears the edge history. A condition that is still true after the write therefore counts once more.
- R12: Register map: address 0 is the configuration, address 1 the counter, address 2 the status. Configuration bits: code [7:0], mask [15:8], threshold [23:16], edge 24, invert 25, supervisor 26, user 27, interrupt enable 28, enable 29. An increment becomes visible on `rd_data` in the cycle after the event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_counts | input | NUM_GROUPS*8*SUB_W | Per-cycle sub-event counts |
| priv | input | 2 | Current privilege level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
The sweeps cover every event code, including the one out of range, several union masks, every threshold value from 0 to 26 with and without inversion, and each combination of the two privilege flags at each level. Any fault in selection or qualification produces a counter value that differs from the arithmetic expectation after only two or three event cycles. A stale edge history or overflow flag shows up at the ports within one cycle, either as a missing or extra count or as a status bit and `irq` that do not match a preset-and-wrap sequence.

// File: rtl/qec_pkg.sv
package qec_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STS = 2'd2;

    typedef struct packed {
        logic [1:0] spare;
        logic       enable;
        logic       irq_en;
        logic       usr;
        logic       os;
        logic       inv;
        logic       edge_only;
        logic [7:0] cmask;
        logic [7:0] umask;
        logic [7:0] code;
    } qec_cfg_t;

endpackage

// File: rtl/qec_select.sv
module qec_select #(
    parameter int NUM_GROUPS = 4,
    parameter int SUB_W      = 2,
    parameter int SUM_W      = 5
) (
    input  logic [NUM_GROUPS*8*SUB_W-1:0] ev_counts,
    input  logic [7:0]                    code,
    input  logic [7:0]                    umask,
    output logic [SUM_W-1:0]              sel_sum
);

    logic [SUM_W-1:0] group_sum [NUM_GROUPS];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        always_comb begin
            group_sum[g] = '0;
            for (int s = 0; s < 8; s++) begin
                if (umask[s]) begin
                    group_sum[g] = group_sum[g]
                        + SUM_W'(ev_counts[(g*8+s)*SUB_W +: SUB_W]);
                end
            end
        end
    end

    always_comb begin
        sel_sum = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (code == 8'(g)) begin
                sel_sum = group_sum[g];
            end
        end
    end

endmodule

// File: rtl/qec_qualify.sv
module qec_qualify #(
    parameter int SUM_W = 5,
    parameter int INC_W = 4
) (
    input  logic [SUM_W-1:0] sel_sum,
    input  logic [7:0]       cmask,
    input  logic             inv,
    input  logic             os,
    input  logic             usr,
    input  logic             enable,
    input  logic [1:0]       priv,
    output logic             qual,
    output logic [INC_W-1:0] inc_amt
);

    localparam int INC_MAX = (1 << INC_W) - 1;
    localparam int CMP_W   = SUM_W + 8;

    logic [CMP_W-1:0] sum_ext;
    logic [CMP_W-1:0] mask_ext;
    logic             priv_ok;
    logic             meets;
    logic             cond;

    always_comb begin
        sum_ext  = CMP_W'(sel_sum);
        mask_ext = CMP_W'(cmask);
        priv_ok  = (!os && !usr)
                 || (os  && (priv == 2'd0))
                 || (usr && (priv != 2'd0));
        meets    = (sum_ext >= mask_ext);
        if (cmask != 8'd0) begin
            cond    = inv ? !meets : meets;
            inc_amt = INC_W'(1);
        end else begin
            cond = (sel_sum != '0);
            if (int'(sel_sum) > INC_MAX) begin
                inc_amt = INC_W'(INC_MAX);
            end else begin
                inc_amt = INC_W'(sel_sum);
            end
        end
        qual = enable && priv_ok && cond;
    end

endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int SUB_W      = 2,
    parameter int CNT_W      = 16,
    parameter int INC_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*8*SUB_W-1:0] ev_counts,
    input  logic [1:0]                    priv,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          irq
);

    localparam int SUM_W = $clog2(8 * ((1 << SUB_W) - 1) + 1);

    typedef struct packed {
        qec_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             prev;
    } state_t;

    state_t st_d, st_q;

    logic [SUM_W-1:0] sel_sum;
    logic             qual;
    logic [INC_W-1:0] inc_amt;
    logic             bump;
    logic [INC_W-1:0] step;
    logic [CNT_W:0]   sum_wide;
    logic             blocked;

    qec_select #(
        .NUM_GROUPS (NUM_GROUPS),
        .SUB_W      (SUB_W),
        .SUM_W      (SUM_W)
    ) u_select (
        .ev_counts (ev_counts),
        .code      (st_q.cfg.code),
        .umask     (st_q.cfg.umask),
        .sel_sum   (sel_sum)
    );

    qec_qualify #(
        .SUM_W (SUM_W),
        .INC_W (INC_W)
    ) u_qualify (
        .sel_sum (sel_sum),
        .cmask   (st_q.cfg.cmask),
        .inv     (st_q.cfg.inv),
        .os      (st_q.cfg.os),
        .usr     (st_q.cfg.usr),
        .enable  (st_q.cfg.enable),
        .priv    (priv),
        .qual    (qual),
        .inc_amt (inc_amt)
    );

    always_comb begin
        st_d    = st_q;
        bump    = st_q.cfg.edge_only ? (qual && !st_q.prev) : qual;
        step    = st_q.cfg.edge_only ? INC_W'(1) : inc_amt;
        blocked = wr_en && ((wr_addr == ADDR_CFG) || (wr_addr == ADDR_CNT));
        sum_wide = {1'b0, st_q.cnt} + (CNT_W+1)'(step);

        st_d.prev = qual;

        if (wr_en) begin
            case (wr_addr)
                ADDR_CFG: begin
                    st_d.cfg  = qec_cfg_t'(wr_data);
                    st_d.prev = 1'b0;
                end
                ADDR_CNT: st_d.cnt = wr_data[CNT_W-1:0];
                ADDR_STS: if (wr_data[0]) st_d.ovf = 1'b0;
                default: ;
            endcase
        end

        if (bump && !blocked) begin
            st_d.cnt = sum_wide[CNT_W-1:0];
            if (sum_wide[CNT_W]) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CFG: rd_data = DATA_W'(st_q.cfg);
            ADDR_CNT: rd_data = DATA_W'(st_q.cnt);
            ADDR_STS: rd_data = DATA_W'(st_q.ovf);
            default:  rd_data = '0;
        endcase
    end

    assign irq = st_q.ovf && st_q.cfg.irq_en;

endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [31:0]      cfg_bits,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf
);

    localparam int INC_MAX = (1 << INC_W) - 1;

    // R8: disabled counter holds its value
    a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bits[29] && !wr_en) |=> $stable(cnt));

    // R3: one cycle never advances the counter by more than the saturation limit
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cfg_bits[29]) |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(INC_MAX)));

    // R4: thresholded counting moves by at most one per cycle
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cfg_bits[29] && (cfg_bits[23:16] != 8'd0))
        |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));

    // R6: edge counting moves by at most one per cycle
    a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cfg_bits[29] && cfg_bits[24])
        |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));

    // R9: a preset lands in the next cycle
    a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd1)) |=> (cnt == $past(wr_data[CNT_W-1:0])));

    // R10: the flag stays set until a clear is written
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && (wr_addr == 2'd2) && wr_data[0])) |=> ovf);

    // R10: the flag only rises on a wrap
    a_r10_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (cnt < $past(cnt)));

endmodule

bind qual_event_counter qec_checker #(
    .CNT_W (CNT_W),
    .INC_W (INC_W)
) u_qec_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg_bits (32'(st_q.cfg)),
    .cnt      (st_q.cnt),
    .ovf      (st_q.ovf)
);

// File: tb/qual_event_counter_bench.sv
module qual_event_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NG    = 4;
    localparam int SW    = 2;
    localparam int CW    = 16;
    localparam int IW    = 4;
    localparam int EV_W  = NG * 8 * SW;
    localparam int SAT   = (1 << IW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [EV_W-1:0] ev_counts = '0;
    logic [1:0]      priv = 2'd0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = 2'd0;
    logic [31:0]     wr_data = '0;
    logic [1:0]      rd_addr = 2'd0;
    logic [31:0]     rd_data;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qual_event_counter #(
        .NUM_GROUPS (NG),
        .SUB_W      (SW),
        .CNT_W      (CW),
        .INC_W      (IW)
    ) u_qual_event_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_counts (ev_counts),
        .priv      (priv),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    function automatic int sub_val(int g, int s, int seed);
        return (g * 5 + s * 3 + seed) % 4;
    endfunction

    function automatic logic [EV_W-1:0] make_vec(int seed);
        logic [EV_W-1:0] v = '0;
        for (int g = 0; g < NG; g++)
            for (int s = 0; s < 8; s++)
                v[(g*8+s)*SW +: SW] = SW'(sub_val(g, s, seed));
        return v;
    endfunction

    function automatic int exp_sum(int code, logic [7:0] mask, int seed);
        int t = 0;
        if (code >= NG) return 0;
        for (int s = 0; s < 8; s++)
            if (mask[s]) t += sub_val(code, s, seed);
        return t;
    endfunction

    function automatic int sat(int v);
        return (v > SAT) ? SAT : v;
    endfunction

    function automatic logic [31:0] mk_cfg(int code, logic [7:0] mask, int cm,
                                           bit edg, bit inv, bit os, bit usr,
                                           bit ie, bit en);
        return {2'b00, en, ie, usr, os, inv, edg, 8'(cm), mask, 8'(code)};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // configure, preset zero, hold a vector for n cycles, return the count
    task automatic trial(logic [31:0] cfg, logic [EV_W-1:0] vec, int n,
                         output logic [31:0] res);
        ev_counts = '0;
        wr(2'd0, cfg);
        wr(2'd1, 32'd0);
        ev_counts = vec;
        repeat (n) tick();
        rd(2'd1, res);
        ev_counts = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  masks [5];
        int          s0;
        int          e;
        bit          pat [10];
        bit          prev;

        masks[0] = 8'h01; masks[1] = 8'hFF; masks[2] = 8'hE1;
        masks[3] = 8'h3C; masks[4] = 8'h80;

        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, r); check("R1 cfg", r, 0);
        rd(2'd1, r); check("R1 cnt", r, 0);
        rd(2'd2, r); check("R1 status", r, 0);
        check("R1 irq", irq, 0);

        // R2 / R3 / R12: selection and saturated raw count
        for (int seed = 0; seed < 2; seed++)
            for (int code = 0; code <= NG; code++)
                for (int m = 0; m < 5; m++) begin
                    trial(mk_cfg(code, masks[m], 0, 0, 0, 0, 0, 0, 1),
                          make_vec(seed), 2, r);
                    check("R2 R3 select", r, 2 * sat(exp_sum(code, masks[m], seed)));
                end

        // R4 / R5: threshold sweep, with and without inversion
        for (int seed = 0; seed < 2; seed++) begin
            s0 = exp_sum(1, 8'hFF, seed);
            for (int cm = 0; cm <= 26; cm++) begin
                trial(mk_cfg(1, 8'hFF, cm, 0, 0, 0, 0, 0, 1), make_vec(seed), 3, r);
                e = (cm == 0) ? 3 * sat(s0) : ((s0 >= cm) ? 3 : 0);
                check("R4 threshold", r, e);
                trial(mk_cfg(1, 8'hFF, cm, 0, 1, 0, 0, 0, 1), make_vec(seed), 3, r);
                e = (cm == 0) ? 3 * sat(s0) : ((s0 < cm) ? 3 : 0);
                check("R5 invert", r, e);
            end
        end

        // R7: privilege filter
        s0 = exp_sum(0, 8'h0F, 0);
        for (int f = 0; f < 4; f++)
            for (int p = 0; p < 4; p++) begin
                priv = 2'(p);
                trial(mk_cfg(0, 8'h0F, 0, 0, 0, f[0], f[1], 0, 1), make_vec(0), 2, r);
                e = ((f == 0) || (f[0] && p == 0) || (f[1] && p != 0)) ? 2 * sat(s0) : 0;
                check("R7 privilege", r, e);
            end
        priv = 2'd0;

        // R8: disabled
        trial(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 0, 0), make_vec(0), 3, r);
        check("R8 disabled", r, 0);

        // R6: edge counting of a pattern
        pat = '{1, 1, 0, 1, 0, 0, 1, 1, 1, 0};
        ev_counts = '0;
        wr(2'd0, mk_cfg(0, 8'hFF, 0, 1, 0, 0, 0, 0, 1));
        wr(2'd1, 32'd0);
        e = 0; prev = 0;
        for (int i = 0; i < 10; i++) begin
            ev_counts = pat[i] ? make_vec(0) : '0;
            if (pat[i] && !prev) e++;
            prev = pat[i];
            tick();
        end
        ev_counts = '0;
        rd(2'd1, r);
        check("R6 edge pattern", r, e);

        // R6 with threshold: high/low vectors around cmask
        s0 = exp_sum(2, 8'hFF, 0);
        wr(2'd0, mk_cfg(2, 8'hFF, s0, 1, 0, 0, 0, 0, 1));
        wr(2'd1, 32'd0);
        for (int i = 0; i < 6; i++) begin
            ev_counts = (i % 3 == 2) ? '0 : make_vec(0);
            tick();
        end
        ev_counts = '0;
        rd(2'd1, r);
        check("R6 edge threshold", r, 2);

        // R11: config rewrite while condition is held
        wr(2'd0, mk_cfg(0, 8'hFF, 0, 1, 0, 0, 0, 0, 1));
        wr(2'd1, 32'd0);
        ev_counts = make_vec(0);
        repeat (3) tick();
        rd(2'd1, r); check("R11 first edge", r, 1);
        wr(2'd0, mk_cfg(0, 8'hFF, 0, 1, 0, 0, 0, 0, 1));
        repeat (3) tick();
        rd(2'd1, r); check("R11 edge after rewrite", r, 2);
        ev_counts = '0;

        // R9: preset, and write beats increment
        wr(2'd0, mk_cfg(0, 8'h01, 0, 0, 0, 0, 0, 0, 1));
        wr(2'd1, 32'h1234);
        rd(2'd1, r); check("R9 preset", r, 32'h1234);
        s0 = exp_sum(0, 8'h01, 1);
        ev_counts = make_vec(1);
        wr(2'd1, 32'h00AA);
        rd(2'd1, r); check("R9 write wins", r, 32'h00AA);
        tick();
        rd(2'd1, r); check("R9 count after preset", r, 32'h00AA + sat(s0));
        ev_counts = '0;

        // R10: wrap with interrupt enabled
        s0 = exp_sum(0, 8'hFF, 0);
        wr(2'd0, mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 1, 1));
        wr(2'd1, 32'(16'hFFFF - 1));
        ev_counts = make_vec(0);
        tick();
        ev_counts = '0;
        rd(2'd1, r); check("R10 wrapped value", r, (sat(s0) - 2) & 16'hFFFF);
        rd(2'd2, r); check("R10 status set", r, 1);
        check("R10 irq high", irq, 1);
        repeat (2) tick();
        rd(2'd2, r); check("R10 status sticky", r, 1);
        wr(2'd2, 32'd1);
        rd(2'd2, r); check("R10 status cleared", r, 0);
        check("R10 irq low", irq, 0);

        // R10: wrap with interrupt disabled
        wr(2'd0, mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 0, 1));
        wr(2'd1, 32'hFFFF);
        ev_counts = make_vec(0);
        tick();
        ev_counts = '0;
        rd(2'd2, r); check("R10 status no irq_en", r, 1);
        check("R10 irq masked", irq, 0);

        // R10: wrap wins over simultaneous clear
        wr(2'd1, 32'hFFFF);
        ev_counts = make_vec(0);
        wr(2'd2, 32'd1);
        ev_counts = '0;
        rd(2'd2, r); check("R10 set beats clear", r, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule